// File: doc/BRIEF.md
# Windowed Software Watchdog

This block is a down-counting watchdog that watches over running software. Software must service it by writing a two-word key sequence to a service register before the counter runs out. If the counter runs out, or if the service is wrong or comes too early, the block raises an interrupt, a system reset request, or an interrupt first and a reset request on the next expiry. The software chooses which.

A small register interface sets the enable, the servicing mode, the response, the counting source and a sticky lock. The timeout length can be written only once after reset. A reset-time input decides whether the counter runs from reset or waits for software to start it. The counter advances on one of two tick strobes: one is derived from the system clock and the other from an internal oscillator. It can also be told to stand still while a low-power indication is high. The reset generator and the clock sources themselves lie outside the block.

Top module: `wdog_guard`

## Requirements
- R1: The register addresses are 0 for control, 1 for timeout, 2 for window and 3 for service writes / counter reads. Out of reset, control reads 0 except bit 0 (enable), which takes the value of `cfg_en_at_reset`. The counter and the timeout hold `DEF_TIMEOUT`, and `irq` and `rst_req` are low. With enable low the counter does not move.
- R2: While control bit 0 is set, the counter drops by one on each edge where the selected tick is high. The expiry comes exactly TO selected ticks after the counter was last loaded with TO, and the counter is then reloaded with TO.
- R3: The first write to the timeout register after reset stores the value and loads the counter with it. Every later timeout write is ignored.
- R4: With control bits 4:3 = 0 (or 3), an expiry sets `rst_req`, which stays high until reset.
- R5: With control bits 4:3 = 1, an expiry sets `irq` and never sets `rst_req`.
- R6: With control bits 4:3 = 2, an expiry sets `irq` if `irq` is low. If `irq` is still high, the expiry sets `rst_req` instead.
- R7: A valid service is a write of 16'hA602 to address 3 followed by a write of 16'hB480 to address 3. It reloads the counter with the timeout value and clears `irq`.
- R8: While enabled, any other value written to address 3, or 16'hB480 written without a preceding 16'hA602, counts as an expiry on the edge of that write.
- R9: With control bit 1 (window mode) set, completing a service while the counter is above the window register counts as an expiry. At or below the window value the service is valid.
- R10: With control bit 2 set, the counter holds its value while `lp_mode` is high.
- R11: Control bit 5 selects the tick source: 0 selects `sys_tick` and 1 selects `osc_tick`. The unselected strobe has no effect.
- R12: Once control bit 6 (lock) is written as 1, all further control writes are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_at_reset | input | 1 | Reset value of the enable bit |
| sys_tick | input | 1 | Count strobe from the system clock domain |
| osc_tick | input | 1 | Count strobe from the internal oscillator |
| lp_mode | input | 1 | Low-power mode indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | Sticky system reset request |

## Verification
A register write takes effect on the clock edge that samples it, so its effect shows on the read port and the outputs right after that edge. An invalid or early service therefore shows `irq` or `rst_req` immediately after the edge of the offending write. A reload with value TO produces its expiry exactly TO edges later. The bench drives every input just after an edge and samples 1 ns after each edge. It counts edges from the reload edge and compares the count with TO. It also reads the counter after a known number of edges to confirm holds and decrements.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int BUS_W = 16;

    localparam logic [BUS_W-1:0] KEY_FIRST  = 16'hA602;
    localparam logic [BUS_W-1:0] KEY_SECOND = 16'hB480;

    typedef enum logic [1:0] {
        RESP_RESET          = 2'd0,
        RESP_IRQ            = 2'd1,
        RESP_IRQ_THEN_RESET = 2'd2,
        RESP_SPARE          = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        ADDR_CTRL    = 2'd0,
        ADDR_TIMEOUT = 2'd1,
        ADDR_WINDOW  = 2'd2,
        ADDR_SERVICE = 2'd3
    } addr_e;

    // bit 6 lock, bit 5 oscillator select, bits 4:3 response,
    // bit 2 low-power hold, bit 1 window mode, bit 0 enable
    typedef struct packed {
        logic  lock;
        logic  osc_sel;
        resp_e resp;
        logic  lp_stop;
        logic  win_mode;
        logic  en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick (
    input  logic sys_tick,
    input  logic osc_tick,
    input  logic osc_sel,
    input  logic en,
    input  logic lp_stop,
    input  logic lp_mode,
    output logic step
);
    logic strobe;

    always_comb begin
        strobe = osc_sel ? osc_tick : sys_tick;
        step   = en && strobe && !(lp_stop && lp_mode);
    end
endmodule

// File: rtl/wdog_keycheck.sv
module wdog_keycheck
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             svc_wr,
    input  logic [BUS_W-1:0] data,
    input  logic             armed,
    input  logic             win_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] win,
    output logic             good,
    output logic             bad,
    output logic             arm_next
);
    logic is_first;
    logic is_second;
    logic too_early;

    always_comb begin
        is_first  = (data == KEY_FIRST);
        is_second = (data == KEY_SECOND);
        too_early = win_mode && (cnt > win);
        good      = svc_wr && armed && is_second && !too_early;
        bad       = svc_wr && ((is_second && (!armed || too_early))
                               || (!is_first && !is_second));
        arm_next  = svc_wr ? is_first : armed;
    end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdg_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int unsigned DEF_TIMEOUT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en_at_reset,
    input  logic             sys_tick,
    input  logic             osc_tick,
    input  logic             lp_mode,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic             irq,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] CNT_DEF = CNT_W'(DEF_TIMEOUT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tmo;
        logic [CNT_W-1:0] win;
        logic             tmo_locked;
        logic             armed;
        logic             irq;
        logic             rst_req;
    } state_t;

    state_t q, d, init_s;

    logic step_w;
    logic svc_wr;
    logic good_svc, bad_svc, arm_next;
    logic expire, fire;

    wdog_tick u_tick (
        .sys_tick (sys_tick),
        .osc_tick (osc_tick),
        .osc_sel  (q.ctrl.osc_sel),
        .en       (q.ctrl.en),
        .lp_stop  (q.ctrl.lp_stop),
        .lp_mode  (lp_mode),
        .step     (step_w)
    );

    assign svc_wr = wr_en && (wr_addr == ADDR_SERVICE) && q.ctrl.en;

    wdog_keycheck #(.CNT_W(CNT_W)) u_keys (
        .svc_wr   (svc_wr),
        .data     (wr_data),
        .armed    (q.armed),
        .win_mode (q.ctrl.win_mode),
        .cnt      (q.cnt),
        .win      (q.win),
        .good     (good_svc),
        .bad      (bad_svc),
        .arm_next (arm_next)
    );

    always_comb begin
        init_s         = '0;
        init_s.ctrl.en = cfg_en_at_reset;
        init_s.cnt     = CNT_DEF;
        init_s.tmo     = CNT_DEF;
        init_s.win     = '1;
    end

    always_comb begin
        d       = q;
        expire  = step_w && (q.cnt <= CNT_ONE);
        fire    = (expire && !good_svc) || bad_svc;
        d.armed = arm_next;

        if (step_w && !expire) begin
            d.cnt = q.cnt - CNT_ONE;
        end

        if (good_svc) begin
            d.cnt = q.tmo;
            d.irq = 1'b0;
        end

        if (fire) begin
            d.cnt = q.tmo;
            case (q.ctrl.resp)
                RESP_IRQ: d.irq = 1'b1;
                RESP_IRQ_THEN_RESET: begin
                    if (q.irq) d.rst_req = 1'b1;
                    else       d.irq     = 1'b1;
                end
                default: d.rst_req = 1'b1;
            endcase
        end

        if (wr_en) begin
            case (addr_e'(wr_addr))
                ADDR_CTRL: begin
                    if (!q.ctrl.lock) d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                end
                ADDR_TIMEOUT: begin
                    if (!q.tmo_locked) begin
                        d.tmo        = wr_data[CNT_W-1:0];
                        d.cnt        = wr_data[CNT_W-1:0];
                        d.tmo_locked = 1'b1;
                    end
                end
                ADDR_WINDOW: d.win = wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= init_s;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        case (addr_e'(rd_addr))
            ADDR_CTRL:    rd_data[CTRL_W-1:0] = q.ctrl;
            ADDR_TIMEOUT: rd_data[CNT_W-1:0]  = q.tmo;
            ADDR_WINDOW:  rd_data[CNT_W-1:0]  = q.win;
            default:      rd_data[CNT_W-1:0]  = q.cnt;
        endcase
    end

    assign irq     = q.irq;
    assign rst_req = q.rst_req;

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lp_mode,
    input logic             wr_en,
    input logic             irq,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] tmo,
    input logic             tmo_locked,
    input ctrl_t            ctrl
);
    p_cnt_le_tmo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= tmo);

    p_tmo_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_locked |=> $stable(tmo));

    p_rst_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    p_irq_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.resp == RESP_IRQ && !rst_req) |=> !rst_req);

    p_irq_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.resp == RESP_IRQ_THEN_RESET && !irq && !rst_req) |=> !rst_req);

    p_lp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.lp_stop && lp_mode && !wr_en) |=> $stable(cnt));

    p_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.lock |=> (ctrl.lock && $stable(ctrl)));
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_mode    (lp_mode),
    .wr_en      (wr_en),
    .irq        (irq),
    .rst_req    (rst_req),
    .cnt        (q.cnt),
    .tmo        (q.tmo),
    .tmo_locked (q.tmo_locked),
    .ctrl       (q.ctrl)
);

// File: tb/test_wdog_guard.sv
`timescale 1ns/10ps
module test_wdog_guard;
    import wdg_pkg::*;

    localparam int DEF = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en_at_reset = 1'b0;
    logic        sys_tick = 1'b1;
    logic        osc_tick = 1'b0;
    logic        lp_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wdog_guard #(.CNT_W(16), .DEF_TIMEOUT(DEF)) i_wdog_guard (
        .clk(clk), .rst_n(rst_n), .cfg_en_at_reset(cfg_en_at_reset),
        .sys_tick(sys_tick), .osc_tick(osc_tick), .lp_mode(lp_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a; #0.1;
        v = int'(rd_data);
    endtask

    task automatic do_reset(input logic cfg);
        rst_n = 1'b0; cfg_en_at_reset = cfg; wr_en = 1'b0;
        lp_mode = 1'b0; sys_tick = 1'b1; osc_tick = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic service;
        wr(2'd3, KEY_FIRST);
        wr(2'd3, KEY_SECOND);
    endtask

    task automatic measure(input bit use_rst, output int n);
        n = 0;
        while (((use_rst ? rst_req : irq) == 1'b0) && n < 500) begin
            step(1);
            n++;
        end
    endtask

    initial begin
        int v, n;
        @(posedge clk); #1;

        // R1 reset state, software start
        do_reset(1'b0);
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd3, v); chk("R1 cnt", v, DEF);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);
        step(5);
        rd(2'd3, v); chk("R1 cnt idle", v, DEF);

        // R1 started from reset
        do_reset(1'b1);
        rd(2'd0, v); chk("R1 ctrl en", v, 1);
        step(5);
        rd(2'd3, v); chk("R1 R2 cnt run", v, DEF - 5);

        // R3 write once
        do_reset(1'b0);
        wr(2'd1, 16'd10);
        rd(2'd1, v); chk("R3 first", v, 10);
        rd(2'd3, v); chk("R3 load", v, 10);
        wr(2'd1, 16'd7);
        rd(2'd1, v); chk("R3 ignored", v, 10);
        rd(2'd3, v); chk("R3 cnt kept", v, 10);

        // R2 R4 R5 sweep of timeout and response
        for (int t = 1; t <= 12; t++) begin
            for (int m = 0; m < 2; m++) begin
                do_reset(1'b0);
                wr(2'd1, 16'(t));
                wr(2'd0, (m == 1) ? 16'h0009 : 16'h0001);
                measure(m == 0, n);
                if (m == 0) begin
                    chk("R2 R4 delay", n, t);
                    chk("R4 no irq", irq, 0);
                    step(3);
                    chk("R4 sticky", rst_req, 1);
                end else begin
                    chk("R2 R5 delay", n, t);
                    step(2 * t + 1);
                    chk("R5 no reset", rst_req, 0);
                    chk("R5 irq held", irq, 1);
                end
            end
        end

        // R6 irq then reset
        do_reset(1'b0);
        wr(2'd1, 16'd6);
        wr(2'd0, 16'h0011);
        measure(1'b0, n); chk("R6 irq first", n, 6);
        chk("R6 no reset yet", rst_req, 0);
        measure(1'b1, n); chk("R6 reset next", n, 6);

        // R6 R7 service clears irq, so next expiry is irq again
        do_reset(1'b0);
        wr(2'd1, 16'd6);
        wr(2'd0, 16'h0011);
        measure(1'b0, n);
        step(2);
        service;
        chk("R7 irq cleared", irq, 0);
        measure(1'b0, n); chk("R6 R7 irq again", n, 6);
        chk("R6 no reset after clear", rst_req, 0);

        // R2 R7 reload
        do_reset(1'b0);
        wr(2'd1, 16'd10);
        wr(2'd0, 16'h0009);
        step(4);
        rd(2'd3, v); chk("R2 decrement", v, 6);
        service;
        rd(2'd3, v); chk("R7 reload", v, 10);
        measure(1'b0, n); chk("R7 delay after service", n, 10);

        // R8 invalid services
        do_reset(1'b0);
        wr(2'd1, 16'd10); wr(2'd0, 16'h0009); step(2);
        wr(2'd3, 16'h1234);
        chk("R8 bad value", irq, 1);
        do_reset(1'b0);
        wr(2'd1, 16'd10); wr(2'd0, 16'h0009); step(2);
        wr(2'd3, KEY_SECOND);
        chk("R8 second alone", irq, 1);
        do_reset(1'b0);
        wr(2'd1, 16'd10); wr(2'd0, 16'h0009); step(2);
        wr(2'd3, KEY_FIRST);
        chk("R8 first ok", irq, 0);
        wr(2'd3, 16'h5555);
        chk("R8 wrong follow", irq, 1);

        // R9 window boundaries: counter at completion 17, 6, 5
        for (int k = 0; k < 3; k++) begin
            do_reset(1'b0);
            wr(2'd1, 16'd20); wr(2'd2, 16'd5); wr(2'd0, 16'h000B);
            step(k == 0 ? 2 : (k == 1 ? 13 : 14));
            service;
            chk("R9 window", irq, (k == 2) ? 0 : 1);
            if (k == 2) begin
                rd(2'd3, v); chk("R9 reload", v, 20);
            end
        end

        // R10 low-power hold
        do_reset(1'b0);
        wr(2'd1, 16'd20);
        lp_mode = 1'b1;
        wr(2'd0, 16'h000D);
        step(5);
        rd(2'd3, v); chk("R10 held", v, 20);
        lp_mode = 1'b0;
        step(3);
        rd(2'd3, v); chk("R10 runs", v, 17);
        lp_mode = 1'b1;
        wr(2'd0, 16'h0009);
        step(3);
        rd(2'd3, v); chk("R10 hold off", v, 14);
        lp_mode = 1'b0;

        // R11 tick select
        do_reset(1'b0);
        wr(2'd1, 16'd20);
        wr(2'd0, 16'h0029);
        step(5);
        rd(2'd3, v); chk("R11 sys ignored", v, 20);
        osc_tick = 1'b1; sys_tick = 1'b0;
        step(4);
        rd(2'd3, v); chk("R11 osc counts", v, 16);
        osc_tick = 1'b0; sys_tick = 1'b1;

        // R12 lock
        do_reset(1'b0);
        wr(2'd1, 16'd20);
        wr(2'd0, 16'h0049);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); chk("R12 ctrl kept", v, 16'h0049);
        step(2);
        rd(2'd3, v); chk("R12 still enabled", v, 17);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule